// File: doc/BRIEF.md
# Microcontroller interrupt option controller

This block is the interrupt front end of a small 8-bit microcontroller. It holds one write-only option register on a simple register bus. It turns two external pin sources and a handful of peripheral flags into five request lines for the CPU: a non-maskable interrupt and four maskable vectors. It also drives a wake-up request for the low-power modes.

External source one is the OR of the enabled port A and port B pins. An option bit makes it level sensitive or rising-edge sensitive. External source two is the OR of the enabled port C pins, and an option bit picks which edge it reacts to. Both sources, and the NMI pin, pass through a two-flop synchroniser. Edge events set a pending latch, and the matching acknowledge clears it. Peripheral flags are gated by their own enable and by the global enable, then merged into their vectors. Of all pending requests, only the one with the highest priority is presented to the CPU.

Top module: `irq_option_ctrl`

## Requirements
- R1: After reset all option bits are 0. An enabled peripheral request then raises no `irq_o` bit and no `wake_o`.
- R2: A write with `reg_addr_i` = 0xC8 loads the option bits from data bit 6 (source-one level mode), bit 5 (source-two rising edge) and bit 4 (global enable). Writes to other addresses are ignored. Data bits 7 and 3..0 are ignored.
- R3: `reg_rdata_o` always reads 0, whatever was written.
- R4: With bit 6 = 1, `irq_o[1]` follows the synchronised source one. With bit 6 = 0, a rising edge of source one sets a pending request. That request holds after the pin falls, until a cycle with `ack_i[1]` = 1.
- R5: With bit 5 = 1, a rising edge of source two sets the vector-2 pending latch. With bit 5 = 0, a falling edge sets it. The other edge has no effect. `ack_i[2]` clears the latch.
- R6: While the global enable is 0, vectors 1 to 4 are never raised. Edges that arrive during that time are not remembered.
- R7: Each peripheral flag counts only when both its own enable and the global enable are 1. The serial end-of-transmission flag goes to vector 2. The auto-reload timer's overflow, compare and edge flags go to vector 3. Timer overflow and A/D end-of-conversion go to vector 4.
- R8: A rising edge on `nmi_i` sets an NMI pending latch whatever the global enable is. `ack_i[0]` clears it.
- R9: `irq_o` is one-hot or zero. Bit 0 is NMI and bits 1 to 4 are vectors 1 to 4. The highest-priority pending request is shown, with NMI above vector 1, then 2, 3 and 4.
- R10: `wake_o` is 1 exactly when the global enable is 1 and any request (NMI included) is pending. A pending NMI with the global enable at 0 gives no wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | AW | Register address |
| reg_wdata_i | input | DW | Write data |
| reg_rdata_o | output | DW | Read data, always zero |
| pa_pin_i | input | PA_W | Port A pin interrupt inputs |
| pa_en_i | input | PA_W | Port A per-pin enables |
| pb_pin_i | input | PB_W | Port B pin interrupt inputs |
| pb_en_i | input | PB_W | Port B per-pin enables |
| pc_pin_i | input | PC_W | Port C pin interrupt inputs |
| pc_en_i | input | PC_W | Port C per-pin enables |
| nmi_i | input | 1 | Non-maskable interrupt pin |
| tmr_ovf_i | input | 1 | Timer overflow flag |
| tmr_ovf_en_i | input | 1 | Timer overflow enable |
| adc_eoc_i | input | 1 | A/D end-of-conversion flag |
| adc_eoc_en_i | input | 1 | A/D interrupt enable |
| art_ovf_i | input | 1 | Auto-reload timer overflow flag |
| art_ovf_en_i | input | 1 | Auto-reload overflow enable |
| art_cmp_i | input | 1 | Auto-reload compare-match flag |
| art_cmp_en_i | input | 1 | Auto-reload compare enable |
| art_edge_i | input | 1 | Auto-reload external-edge flag |
| art_edge_en_i | input | 1 | Auto-reload edge enable |
| spi_eot_i | input | 1 | Serial end-of-transmission flag |
| spi_eot_en_i | input | 1 | Serial interrupt enable |
| ack_i | input | 5 | Per-request acknowledge, same order as irq_o |
| irq_o | output | 5 | One-hot presented request |
| wake_o | output | 1 | Low-power wake-up request |

## Verification
The assertions assume the following about the inputs:
- `ack_i` only names a request that is being presented.
- A write to the option register does not fall in the same cycle as an acknowledge.
- Peripheral flags are already synchronous.

The stimulus applies a write, an acknowledge or a pin change only on the falling clock edge, and never two of these in the same cycle. It then waits three rising edges after any pin change before sampling, which covers the two synchroniser stages and the pending latch.

// File: rtl/irq_opt_pkg.sv
package irq_opt_pkg;
  localparam int NVEC     = 5;
  localparam int VEC_NMI  = 0;
  localparam int VEC_1    = 1;
  localparam int VEC_2    = 2;
  localparam int VEC_3    = 3;
  localparam int VEC_4    = 4;
  localparam int LVL1_BIT = 6;
  localparam int POL2_BIT = 5;
  localparam int GEN_BIT  = 4;

  typedef enum logic {
    COND_LVL_EDGE = 1'b0,
    COND_POL_EDGE = 1'b1
  } cond_mode_e;

  typedef struct packed {
    logic lvl1;
    logic pol2;
    logic gen;
  } opt_t;
endpackage

// File: rtl/irq_opt_reg.sv
module irq_opt_reg
  import irq_opt_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [AW-1:0] REG_ADDR = 'hC8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output opt_t          opt_o
);
  logic hit;
  logic wdata_unused;

  assign hit          = we_i && (addr_i == REG_ADDR);
  assign wdata_unused = ^{wdata_i[DW-1:LVL1_BIT+1], wdata_i[GEN_BIT-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opt_o <= '0;
    end else if (hit) begin
      opt_o.lvl1 <= wdata_i[LVL1_BIT];
      opt_o.pol2 <= wdata_i[POL2_BIT];
      opt_o.gen  <= wdata_i[GEN_BIT];
    end
  end
endmodule

// File: rtl/irq_ext_cond.sv
module irq_ext_cond
  import irq_opt_pkg::*;
#(
  parameter cond_mode_e MODE = COND_LVL_EDGE
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  input  logic sel_i,   // LVL_EDGE: 1=level; POL_EDGE: 1=rising
  input  logic arm_i,
  input  logic ack_i,
  output logic req_o
);
  logic s1_q, s2_q, prev_q, pend_q;
  logic rise, fall, edge_hit, lvl_mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= raw_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign rise = s2_q & ~prev_q;
  assign fall = ~s2_q & prev_q;

  generate
    if (MODE == COND_LVL_EDGE) begin : g_lvl_edge
      assign edge_hit = rise;
      assign lvl_mode = sel_i;
    end else begin : g_pol_edge
      assign edge_hit = sel_i ? rise : fall;
      assign lvl_mode = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               pend_q <= 1'b0;
    else if (lvl_mode)         pend_q <= 1'b0;
    else if (arm_i && edge_hit) pend_q <= 1'b1;
    else if (ack_i)            pend_q <= 1'b0;
  end

  assign req_o = arm_i & (lvl_mode ? s2_q : pend_q);
endmodule

// File: rtl/irq_vec_arb.sv
module irq_vec_arb #(
  parameter int N = 5
) (
  input  logic [N-1:0] pend_i,
  output logic [N-1:0] grant_o
);
  // lowest index wins
  assign grant_o = pend_i & (~pend_i + N'(1));
endmodule

// File: rtl/irq_option_ctrl.sv
module irq_option_ctrl
  import irq_opt_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [AW-1:0] REG_ADDR = 'hC8,
  parameter int PA_W = 8,
  parameter int PB_W = 8,
  parameter int PC_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_we_i,
  input  logic [AW-1:0]   reg_addr_i,
  input  logic [DW-1:0]   reg_wdata_i,
  output logic [DW-1:0]   reg_rdata_o,
  input  logic [PA_W-1:0] pa_pin_i,
  input  logic [PA_W-1:0] pa_en_i,
  input  logic [PB_W-1:0] pb_pin_i,
  input  logic [PB_W-1:0] pb_en_i,
  input  logic [PC_W-1:0] pc_pin_i,
  input  logic [PC_W-1:0] pc_en_i,
  input  logic            nmi_i,
  input  logic            tmr_ovf_i,
  input  logic            tmr_ovf_en_i,
  input  logic            adc_eoc_i,
  input  logic            adc_eoc_en_i,
  input  logic            art_ovf_i,
  input  logic            art_ovf_en_i,
  input  logic            art_cmp_i,
  input  logic            art_cmp_en_i,
  input  logic            art_edge_i,
  input  logic            art_edge_en_i,
  input  logic            spi_eot_i,
  input  logic            spi_eot_en_i,
  input  logic [NVEC-1:0] ack_i,
  output logic [NVEC-1:0] irq_o,
  output logic            wake_o
);
  opt_t            opt_q;
  logic            src1_raw, src2_raw;
  logic            src1_req, src2_req, nmi_req;
  logic [NVEC-1:0] pend;

  irq_opt_reg #(.AW(AW), .DW(DW), .REG_ADDR(REG_ADDR)) u_reg (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .opt_o(opt_q)
  );

  assign reg_rdata_o = '0;  // write-only register

  assign src1_raw = |(pa_pin_i & pa_en_i) | |(pb_pin_i & pb_en_i);
  assign src2_raw = |(pc_pin_i & pc_en_i);

  irq_ext_cond #(.MODE(COND_LVL_EDGE)) u_src1 (
    .clk_i, .rst_ni, .raw_i(src1_raw), .sel_i(opt_q.lvl1),
    .arm_i(opt_q.gen), .ack_i(ack_i[VEC_1]), .req_o(src1_req)
  );

  irq_ext_cond #(.MODE(COND_POL_EDGE)) u_src2 (
    .clk_i, .rst_ni, .raw_i(src2_raw), .sel_i(opt_q.pol2),
    .arm_i(opt_q.gen), .ack_i(ack_i[VEC_2]), .req_o(src2_req)
  );

  irq_ext_cond #(.MODE(COND_POL_EDGE)) u_nmi (
    .clk_i, .rst_ni, .raw_i(nmi_i), .sel_i(1'b1),
    .arm_i(1'b1), .ack_i(ack_i[VEC_NMI]), .req_o(nmi_req)
  );

  assign pend[VEC_NMI] = nmi_req;
  assign pend[VEC_1]   = src1_req;
  assign pend[VEC_2]   = src2_req | (opt_q.gen & spi_eot_i & spi_eot_en_i);
  assign pend[VEC_3]   = opt_q.gen & ((art_ovf_i & art_ovf_en_i) |
                                      (art_cmp_i & art_cmp_en_i) |
                                      (art_edge_i & art_edge_en_i));
  assign pend[VEC_4]   = opt_q.gen & ((tmr_ovf_i & tmr_ovf_en_i) |
                                      (adc_eoc_i & adc_eoc_en_i));

  irq_vec_arb #(.N(NVEC)) u_arb (.pend_i(pend), .grant_o(irq_o));

  assign wake_o = opt_q.gen & |pend;
endmodule

// File: rtl/irq_opt_chk.sv
module irq_opt_chk
  import irq_opt_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [AW-1:0] REG_ADDR = 'hC8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            reg_we_i,
  input logic [AW-1:0]   reg_addr_i,
  input logic [DW-1:0]   reg_wdata_i,
  input logic [NVEC-1:0] ack_i,
  input logic [NVEC-1:0] irq_o,
  input logic            wake_o,
  input logic [NVEC-1:0] pend_i,
  input logic            gen_i,
  input logic            lvl1_i
);
  p_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_o));

  p_nmi_first_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_i[VEC_NMI] |-> irq_o[VEC_NMI]);

  p_grant_pending_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i != '0) |-> (irq_o != '0));

  p_gen_block_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gen_i |-> (irq_o[VEC_4:VEC_1] == '0));

  p_wake_gen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> (gen_i && irq_o != '0));

  p_wake_any_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gen_i && irq_o != '0) |-> wake_o);

  p_gen_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == REG_ADDR) |=> (gen_i == $past(reg_wdata_i[GEN_BIT])));

  p_gen_keep_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_i && reg_addr_i == REG_ADDR) |=> $stable(gen_i));

  p_edge_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i[VEC_1] && !lvl1_i && gen_i && !ack_i[VEC_1] && !reg_we_i) |=> pend_i[VEC_1]);

  p_nmi_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i[VEC_NMI] && !ack_i[VEC_NMI]) |=> pend_i[VEC_NMI]);
endmodule

bind irq_option_ctrl irq_opt_chk #(.AW(AW), .DW(DW), .REG_ADDR(REG_ADDR)) u_chk (
  .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .ack_i, .irq_o, .wake_o,
  .pend_i(pend), .gen_i(opt_q.gen), .lvl1_i(opt_q.lvl1)
);

// File: tb/irq_option_ctrl_bench.sv
module irq_option_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 8;
  // {opt[25:18], req[17:12], en[11:6], irq[5:1], wake[0]}
  // req/en order: tmr, adc, art_ovf, art_cmp, art_edge, spi
  localparam logic [25:0] TBL [12] = '{
    {8'h10, 6'b100000, 6'b100000, 5'b10000, 1'b1},
    {8'h10, 6'b010000, 6'b000000, 5'b00000, 1'b0},
    {8'h10, 6'b010000, 6'b010000, 5'b10000, 1'b1},
    {8'h10, 6'b001000, 6'b001000, 5'b01000, 1'b1},
    {8'h10, 6'b000100, 6'b000010, 5'b00000, 1'b0},
    {8'h10, 6'b000010, 6'b000010, 5'b01000, 1'b1},
    {8'h10, 6'b000001, 6'b000001, 5'b00100, 1'b1},
    {8'h10, 6'b111111, 6'b111111, 5'b00100, 1'b1},
    {8'h00, 6'b111111, 6'b111111, 5'b00000, 1'b0},
    {8'h10, 6'b101000, 6'b101000, 5'b01000, 1'b1},
    {8'hEF, 6'b111111, 6'b111111, 5'b00000, 1'b0},
    {8'h90, 6'b100000, 6'b100000, 5'b10000, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0;
  logic [7:0] addr = '0, wdata = '0, rdata;
  logic [PW-1:0] pa_pin = '0, pa_en = '0, pb_pin = '0, pb_en = '0, pc_pin = '0, pc_en = '0;
  logic nmi = 1'b0;
  logic [5:0] req = '0, en = '0;
  logic [4:0] ack = '0, irq;
  logic wake;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_option_ctrl u_irq_option_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .pa_pin_i(pa_pin), .pa_en_i(pa_en), .pb_pin_i(pb_pin), .pb_en_i(pb_en),
    .pc_pin_i(pc_pin), .pc_en_i(pc_en), .nmi_i(nmi),
    .tmr_ovf_i(req[5]), .tmr_ovf_en_i(en[5]),
    .adc_eoc_i(req[4]), .adc_eoc_en_i(en[4]),
    .art_ovf_i(req[3]), .art_ovf_en_i(en[3]),
    .art_cmp_i(req[2]), .art_cmp_en_i(en[2]),
    .art_edge_i(req[1]), .art_edge_en_i(en[1]),
    .spi_eot_i(req[0]), .spi_eot_en_i(en[0]),
    .ack_i(ack), .irq_o(irq), .wake_o(wake)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_ack(input logic [4:0] a);
    @(negedge clk); ack = a;
    @(negedge clk); ack = '0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state blocks an enabled request
    @(negedge clk); req = 6'b100000; en = 6'b100000;
    @(negedge clk);
    check("R1 irq after reset", {3'b0, irq}, 8'h00);
    check("R1 wake after reset", {7'b0, wake}, 8'h00);
    check("R3 rdata after reset", rdata, 8'h00);
    // R2: wrong address ignored
    wr(8'hC9, 8'h10);
    @(negedge clk);
    check("R2 other address ignored", {3'b0, irq}, 8'h00);

    // R7/R2 table walk
    foreach (TBL[i]) begin
      wr(8'hC8, TBL[i][25:18]);
      req = TBL[i][17:12]; en = TBL[i][11:6];
      @(negedge clk);
      check($sformatf("R7 table irq %0d", i), {3'b0, irq}, {3'b0, TBL[i][5:1]});
      check($sformatf("R10 table wake %0d", i), {7'b0, wake}, {7'b0, TBL[i][0]});
      check($sformatf("R3 table rdata %0d", i), rdata, 8'h00);
    end
    req = '0; en = '0;

    // R4 edge mode on source one
    wr(8'hC8, 8'h10);
    pa_en[2] = 1'b1; pa_pin[2] = 1'b1;
    settle();
    check("R4 edge sets pending", {3'b0, irq}, 8'h02);
    pa_pin[2] = 1'b0;
    settle();
    check("R4 edge pending holds", {3'b0, irq}, 8'h02);
    pulse_ack(5'b00010);
    check("R4 ack clears", {3'b0, irq}, 8'h00);
    // R4 level mode
    wr(8'hC8, 8'h50);
    pb_en[0] = 1'b1; pb_pin[0] = 1'b1;
    settle();
    check("R4 level high", {3'b0, irq}, 8'h02);
    pb_pin[0] = 1'b0;
    settle();
    check("R4 level follows low", {3'b0, irq}, 8'h00);

    // R5 rising polarity
    wr(8'hC8, 8'h30);
    pc_en[5] = 1'b1; pc_pin[5] = 1'b1;
    settle();
    check("R5 rising edge", {3'b0, irq}, 8'h04);
    pulse_ack(5'b00100);
    pc_pin[5] = 1'b0;
    settle();
    check("R5 falling ignored when rising set", {3'b0, irq}, 8'h00);
    // R5 falling polarity
    wr(8'hC8, 8'h10);
    pc_pin[5] = 1'b1;
    settle();
    check("R5 rising ignored when falling set", {3'b0, irq}, 8'h00);
    pc_pin[5] = 1'b0;
    settle();
    check("R5 falling edge", {3'b0, irq}, 8'h04);
    pulse_ack(5'b00100);
    check("R5 ack clears", {3'b0, irq}, 8'h00);

    // R6: edge while disabled is not remembered
    wr(8'hC8, 8'h00);
    pa_pin[2] = 1'b1;
    settle();
    check("R6 blocked while disabled", {3'b0, irq}, 8'h00);
    wr(8'hC8, 8'h10);
    @(negedge clk);
    check("R6 no late delivery", {3'b0, irq}, 8'h00);
    pa_pin[2] = 1'b0;
    wr(8'hC8, 8'h40);
    pb_pin[0] = 1'b1;
    settle();
    check("R6 level blocked while disabled", {3'b0, irq}, 8'h00);
    pb_pin[0] = 1'b0;
    settle();

    // R8/R10: NMI with global enable off
    nmi = 1'b1;
    settle();
    check("R8 nmi pending disabled", {3'b0, irq}, 8'h01);
    check("R10 no wake from nmi disabled", {7'b0, wake}, 8'h00);
    wr(8'hC8, 8'h10);
    check("R10 wake from nmi enabled", {7'b0, wake}, 8'h01);
    // R9 priority
    @(negedge clk); req = 6'b100000; en = 6'b100000;
    @(negedge clk);
    check("R9 nmi over vector 4", {3'b0, irq}, 8'h01);
    pulse_ack(5'b00001);
    check("R9 vector 4 after nmi ack", {3'b0, irq}, 8'h10);
    nmi = 1'b0;
    settle();
    check("R8 nmi stays clear", {3'b0, irq}, 8'h10);
    finish_run();
  end
endmodule